// File: doc/BRIEF.md
# Pipeline Data Hazard Interlock Unit

This unit sits beside the decode/operand-read stage (stage 2) of a five-stage load/store pipeline. Each cycle it looks at the instruction in decode and at the destination registers of the three older instructions still in flight, in stages 3, 4 and 5. If any of those results cannot yet reach the decoding instruction, it raises a stall. While stalled, the fetch and decode registers hold and a no-op bubble enters stage 3. The unit keeps its own shadow record of the stage 3 to 5 producers. It fills that record from the decode inputs, so the surrounding pipeline only has to present the decoded instruction and obey the stall.

The spacing needed between a producer and a consumer depends on two things: when the producer's result exists and when the consumer needs it. With forwarding disabled, every result is written back at the end of stage 5 and read in stage 2, so four instructions of spacing are always needed. With forwarding enabled, the producer class and the kind of operand being read give a smaller spacing, taken from a small matrix. A single mode input picks between the two behaviours.

Top module: `hazard_interlock`

## Requirements
- R1: Out of reset the three older stages are empty. `stall_o` and `bubble_o` stay 0 until a producer has been accepted from decode. Class codes are: 0 no-op, 1 alu, 2 load, 3 load-address, 4 store, 5 branch, 6 branch-and-link. Code 7 is treated as a no-op.
- R2: With `fwd_en_i`=0, a consumer stalls while any valid producer in stage 3, 4 or 5 writes a register that the consumer reads. A back-to-back pair therefore costs 3 stall cycles, and a pair with one empty slot between costs 2.
- R3: With `fwd_en_i`=1, an alu or load-address producer causes no stall for alu, load, load-address, store-base or store-data readers. It costs a branch reader 1 stall cycle when back-to-back.
- R4: With `fwd_en_i`=1, a load producer costs 1 stall cycle to an adjacent alu, load, load-address or store-base reader and 2 stall cycles to an adjacent branch. It costs nothing to a store that uses the loaded register as its data register.
- R5: With `fwd_en_i`=1, a branch-and-link producer (link written to `ra`) never causes a stall.
- R6: Each class reads only certain fields:
  - alu reads `rb`, and reads `rc` unless `dec_imm_i`=1.
  - load and load-address read `rb` only.
  - store reads `rb` as its base and `ra` as its data.
  - branch and branch-and-link read `rb` and `rc`, and `dec_imm_i`=1 suppresses `rc`.
  
  Register 0 never creates a dependence.
- R7: In every cycle where `stall_o`=1, a bubble enters stage 3. `bubble_o` is 1 in exactly the cycles that follow a stall cycle, and a bubble never causes a stall.
- R8: No-op, store and branch producers write nothing and never cause a stall. A decode slot with `dec_valid_i`=0 never stalls, and it enters stage 3 as an empty slot.
- R9: A stall never lasts more than three consecutive cycles, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fwd_en_i | input | 1 | 1 = forwarding spacing matrix, 0 = write-back spacing |
| dec_valid_i | input | 1 | Decode stage holds a real instruction |
| dec_cls_i | input | 3 | Class code of the decode instruction (see R1) |
| dec_ra_i | input | REG_W | Destination field, also the store data source |
| dec_rb_i | input | REG_W | First source field |
| dec_rc_i | input | REG_W | Second source field |
| dec_imm_i | input | 1 | Instruction uses an immediate in place of `rc` |
| stall_o | output | 1 | Hold fetch and decode this cycle |
| bubble_o | output | 1 | Stage 3 holds an injected bubble |

## Verification
The bench aims at the asymmetric cells of the forwarded matrix: load into store data (spacing 1), load into branch (spacing 3), and branch-and-link into branch (spacing 1). A design that used one load-use rule everywhere would stall the store needlessly and let the branch read a stale value one cycle early. Register 0, immediate forms and the field usage of each class are driven directly. A design that compared unused fields would show spurious stalls, visible as extra cycles on `stall_o`. Long random streams in both modes, with fields drawn from four registers, check that bubbles drain. A design that let a bubble count as a producer, or that did not keep a stalled instruction out of stage 3, would stall one cycle too long or too short.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_LADR   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_BRL    = 3'd6
  } icls_e;

  // operand need point: general (stage 3), store data (stage 4), branch (stage 2)
  typedef enum logic [1:0] {
    USE_GEN  = 2'd0,
    USE_DATA = 2'd1,
    USE_BR   = 2'd2
  } use_e;

  localparam int NUM_SRC = 3;

  function automatic logic writes_dest(icls_e c);
    return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_LADR) || (c == CLS_BRL);
  endfunction

endpackage

// File: rtl/ilk_src_decode.sv
module ilk_src_decode
  import ilk_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  icls_e             cls_i,
  input  logic [REG_W-1:0]  ra_i,
  input  logic [REG_W-1:0]  rb_i,
  input  logic [REG_W-1:0]  rc_i,
  input  logic              imm_i,
  output logic [REG_W-1:0]  src_reg_o  [NUM_SRC],
  output logic              src_used_o [NUM_SRC],
  output use_e              src_kind_o [NUM_SRC]
);

  // slot 0 = rb, slot 1 = rc, slot 2 = ra (store data)
  always_comb begin
    src_reg_o[0]  = rb_i;
    src_reg_o[1]  = rc_i;
    src_reg_o[2]  = ra_i;
    src_used_o[0] = 1'b0;
    src_used_o[1] = 1'b0;
    src_used_o[2] = 1'b0;
    src_kind_o[0] = USE_GEN;
    src_kind_o[1] = USE_GEN;
    src_kind_o[2] = USE_DATA;
    unique case (cls_i)
      CLS_ALU: begin
        src_used_o[0] = 1'b1;
        src_used_o[1] = !imm_i;
      end
      CLS_LOAD, CLS_LADR: begin
        src_used_o[0] = 1'b1;
      end
      CLS_STORE: begin
        src_used_o[0] = 1'b1;
        src_used_o[2] = 1'b1;
      end
      CLS_BRANCH, CLS_BRL: begin
        src_used_o[0] = 1'b1;
        src_used_o[1] = !imm_i;
        src_kind_o[0] = USE_BR;
        src_kind_o[1] = USE_BR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ilk_sep_lut.sv
module ilk_sep_lut
  import ilk_pkg::*;
#(
  parameter int NUM_OLDER = 3,
  parameter int SEP_W     = $clog2(NUM_OLDER + 2)
) (
  input  icls_e             prod_cls_i,
  input  use_e              kind_i,
  input  logic              fwd_en_i,
  output logic [SEP_W-1:0]  sep_o
);

  localparam logic [SEP_W-1:0] SEP_WB = SEP_W'(NUM_OLDER + 1);

  always_comb begin
    sep_o = SEP_W'(1);
    if (!fwd_en_i) begin
      sep_o = SEP_WB;
    end else begin
      unique case (prod_cls_i)
        CLS_ALU, CLS_LADR: sep_o = (kind_i == USE_BR) ? SEP_W'(2) : SEP_W'(1);
        CLS_LOAD: begin
          unique case (kind_i)
            USE_GEN:  sep_o = SEP_W'(2);
            USE_BR:   sep_o = SEP_W'(3);
            default:  sep_o = SEP_W'(1);
          endcase
        end
        default: sep_o = SEP_W'(1);
      endcase
    end
  end

endmodule

// File: rtl/ilk_stage_cmp.sv
module ilk_stage_cmp
  import ilk_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int NUM_OLDER = 3,
  parameter int DIST      = 1
) (
  input  logic              fwd_en_i,
  input  logic              stg_valid_i,
  input  icls_e             stg_cls_i,
  input  logic [REG_W-1:0]  stg_dst_i,
  input  logic [REG_W-1:0]  src_reg_i  [NUM_SRC],
  input  logic              src_used_i [NUM_SRC],
  input  use_e              src_kind_i [NUM_SRC],
  output logic              hit_o
);

  localparam int SEP_W = $clog2(NUM_OLDER + 2);
  localparam logic [SEP_W-1:0] DIST_V = SEP_W'(DIST);

  logic producer;
  logic [NUM_SRC-1:0] slot_hit;

  assign producer = stg_valid_i && writes_dest(stg_cls_i) && (stg_dst_i != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    logic [SEP_W-1:0] sep;
    ilk_sep_lut #(.NUM_OLDER(NUM_OLDER), .SEP_W(SEP_W)) u_lut (
      .prod_cls_i (stg_cls_i),
      .kind_i     (src_kind_i[s]),
      .fwd_en_i   (fwd_en_i),
      .sep_o      (sep)
    );
    assign slot_hit[s] = src_used_i[s] && (src_reg_i[s] == stg_dst_i) && (DIST_V < sep);
  end

  assign hit_o = producer && |slot_hit;

endmodule

// File: rtl/ilk_track.sv
module ilk_track
  import ilk_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int NUM_OLDER = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  input  icls_e             push_cls_i,
  input  logic [REG_W-1:0]  push_dst_i,
  input  logic              stall_i,
  output logic              stg_valid_o [NUM_OLDER],
  output icls_e             stg_cls_o   [NUM_OLDER],
  output logic [REG_W-1:0]  stg_dst_o   [NUM_OLDER],
  output logic              bubble_o
);

  for (genvar k = 0; k < NUM_OLDER; k++) begin : g_stg
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_valid_o[0] <= 1'b0;
          stg_cls_o[0]   <= CLS_NOP;
          stg_dst_o[0]   <= '0;
        end else begin
          stg_valid_o[0] <= push_valid_i && !stall_i;
          stg_cls_o[0]   <= stall_i ? CLS_NOP : push_cls_i;
          stg_dst_o[0]   <= stall_i ? '0 : push_dst_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_valid_o[k] <= 1'b0;
          stg_cls_o[k]   <= CLS_NOP;
          stg_dst_o[k]   <= '0;
        end else begin
          stg_valid_o[k] <= stg_valid_o[k-1];
          stg_cls_o[k]   <= stg_cls_o[k-1];
          stg_dst_o[k]   <= stg_dst_o[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bubble_o <= 1'b0;
    else         bubble_o <= stall_i;
  end

  if (NUM_OLDER > 1) begin : g_chk
    AST_BUBBLE_MOVES_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bubble_o |=> !stg_valid_o[1]);  // R7
  end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int NUM_OLDER = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic              dec_valid_i,
  input  logic [2:0]        dec_cls_i,
  input  logic [REG_W-1:0]  dec_ra_i,
  input  logic [REG_W-1:0]  dec_rb_i,
  input  logic [REG_W-1:0]  dec_rc_i,
  input  logic              dec_imm_i,
  output logic              stall_o,
  output logic              bubble_o
);

  localparam int RUN_W = $clog2(NUM_OLDER + 2);

  icls_e             dec_cls;
  logic [REG_W-1:0]  src_reg  [NUM_SRC];
  logic              src_used [NUM_SRC];
  use_e              src_kind [NUM_SRC];
  logic              stg_valid [NUM_OLDER];
  icls_e             stg_cls   [NUM_OLDER];
  logic [REG_W-1:0]  stg_dst   [NUM_OLDER];
  logic [NUM_OLDER-1:0] hit;

  assign dec_cls = icls_e'(dec_cls_i);

  ilk_src_decode #(.REG_W(REG_W)) u_dec (
    .cls_i      (dec_cls),
    .ra_i       (dec_ra_i),
    .rb_i       (dec_rb_i),
    .rc_i       (dec_rc_i),
    .imm_i      (dec_imm_i),
    .src_reg_o  (src_reg),
    .src_used_o (src_used),
    .src_kind_o (src_kind)
  );

  for (genvar k = 0; k < NUM_OLDER; k++) begin : g_cmp
    ilk_stage_cmp #(.REG_W(REG_W), .NUM_OLDER(NUM_OLDER), .DIST(k + 1)) u_cmp (
      .fwd_en_i    (fwd_en_i),
      .stg_valid_i (stg_valid[k]),
      .stg_cls_i   (stg_cls[k]),
      .stg_dst_i   (stg_dst[k]),
      .src_reg_i   (src_reg),
      .src_used_i  (src_used),
      .src_kind_i  (src_kind),
      .hit_o       (hit[k])
    );
  end

  assign stall_o = dec_valid_i && |hit;

  ilk_track #(.REG_W(REG_W), .NUM_OLDER(NUM_OLDER)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_valid_i (dec_valid_i),
    .push_cls_i   (dec_cls),
    .push_dst_i   (dec_ra_i),
    .stall_i      (stall_o),
    .stg_valid_o  (stg_valid),
    .stg_cls_o    (stg_cls),
    .stg_dst_o    (stg_dst),
    .bubble_o     (bubble_o)
  );

  // consecutive stall cycles seen before the current one
  logic [RUN_W-1:0] stall_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            stall_run_q <= '0;
    else if (!stall_o)                      stall_run_q <= '0;
    else if (stall_run_q != RUN_W'(NUM_OLDER)) stall_run_q <= stall_run_q + 1'b1;
  end

  AST_BUBBLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> bubble_o);  // R7
  AST_NO_STRAY_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> !bubble_o);  // R7
  AST_STALL_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (stall_run_q < RUN_W'(NUM_OLDER)));  // R9
  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dec_valid_i) |-> !stall_o);  // R8

endmodule

// File: tb/hazard_interlock_tb.sv
module hazard_interlock_tb;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_en = 1'b0;
  logic dvalid = 1'b0;
  logic [2:0] dcls = 3'd0;
  logic [REG_W-1:0] dra = '0, drb = '0, drc = '0;
  logic dimm = 1'b0;
  logic stall, bubble;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hazard_interlock #(.REG_W(REG_W), .NUM_OLDER(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fwd_en_i(fwd_en), .dec_valid_i(dvalid),
    .dec_cls_i(dcls), .dec_ra_i(dra), .dec_rb_i(drb), .dec_rc_i(drc),
    .dec_imm_i(dimm), .stall_o(stall), .bubble_o(bubble)
  );

  // reference: records of stages 3..5
  int m_v[3], m_cls[3], m_dst[3];
  bit exp_bubble = 1'b0;
  bit exp_stall;

  function automatic int avail_stage(int c, bit f);
    if (!f) return 6;
    if (c == 2) return 5;
    if (c == 6) return 2;
    return 4;
  endfunction

  function automatic int need_stage(int kind, bit f);
    if (!f) return 2;
    if (kind == 1) return 4;
    if (kind == 2) return 2;
    return 3;
  endfunction

  function automatic bit model_stall();
    int r[3], kind[3];
    bit used[3];
    bit any = 0;
    if (!dvalid) return 0;
    r[0] = drb; r[1] = drc; r[2] = dra;
    kind[0] = (dcls == 5 || dcls == 6) ? 2 : 0;
    kind[1] = kind[0];
    kind[2] = 1;
    used[0] = (dcls >= 1 && dcls <= 6);
    used[1] = (dcls == 1 || dcls == 5 || dcls == 6) && !dimm;
    used[2] = (dcls == 4);
    for (int k = 0; k < 3; k++) begin
      if (m_v[k] != 0 && m_dst[k] != 0 &&
          (m_cls[k] == 1 || m_cls[k] == 2 || m_cls[k] == 3 || m_cls[k] == 6)) begin
        for (int s = 0; s < 3; s++) begin
          int sep;
          sep = avail_stage(m_cls[k], fwd_en) - need_stage(kind[s], fwd_en);
          if (sep < 1) sep = 1;
          if (used[s] && r[s] == m_dst[k] && (k + 1) < sep) any = 1;
        end
      end
    end
    return any;
  endfunction

  // one cycle: inputs already driven after a falling edge
  task automatic step();
    #2;
    exp_stall = model_stall();
    n_chk++;
    if (stall !== exp_stall) begin
      n_fail++;
      $display("FAIL R2 R3 R4 R5 R6 R8 stall t=%0t cls=%0d actual=%b expected=%b",
               $time, dcls, stall, exp_stall);
    end
    if (bubble !== exp_bubble) begin
      n_fail++;
      $display("FAIL R7 bubble t=%0t actual=%b expected=%b", $time, bubble, exp_bubble);
    end
    @(posedge clk);
    for (int k = 2; k > 0; k--) begin
      m_v[k] = m_v[k-1]; m_cls[k] = m_cls[k-1]; m_dst[k] = m_dst[k-1];
    end
    m_v[0]   = (dvalid && !exp_stall) ? 1 : 0;
    m_cls[0] = (dcls == 7) ? 0 : int'(dcls);
    m_dst[0] = dra;
    exp_bubble = exp_stall;
    @(negedge clk);
  endtask

  task automatic issue(int c, int a, int b, int d, bit im, output int nst);
    dvalid = 1'b1; dcls = 3'(c); dra = REG_W'(a); drb = REG_W'(b); drc = REG_W'(d); dimm = im;
    nst = 0;
    do begin
      step();
      if (exp_stall) nst++;
    end while (exp_stall && nst < 10);
  endtask

  task automatic idle(int n);
    dvalid = 1'b0; dcls = 3'd0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pair(string tag, bit f, int ca, int aa, int ba, int da, bit ia,
                      int cb, int ab, int bb, int db, bit ib, int gap, int exp_n);
    int n;
    fwd_en = f;
    idle(4);
    issue(ca, aa, ba, da, ia, n);
    if (gap > 0) idle(gap);
    issue(cb, ab, bb, db, ib, n);
    n_chk++;
    if (n != exp_n) begin
      n_fail++;
      $display("FAIL %s stall cycles actual=%0d expected=%0d", tag, n, exp_n);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    for (int k = 0; k < 3; k++) begin m_v[k] = 0; m_cls[k] = 0; m_dst[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, reader of r1 with empty pipeline
    dvalid = 1'b1; dcls = 3'd1; drb = 5'd1; drc = 5'd1;
    #2;
    n_chk++;
    if (stall !== 1'b0 || bubble !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset actual=%b%b expected=00", stall, bubble);
    end
    @(negedge clk);
    idle(1);
    // code 7 behaves as no-op producer (R1)
    pair("R1", 0, 7, 1, 0, 0, 0,   1, 2, 1, 0, 0, 0, 0);
    // R2: no forwarding
    pair("R2", 0, 1, 1, 2, 3, 0,   1, 4, 1, 5, 0, 0, 3);
    pair("R2", 0, 1, 1, 2, 3, 0,   1, 4, 1, 5, 0, 1, 2);
    pair("R2", 0, 2, 7, 2, 0, 0,   5, 0, 0, 7, 0, 2, 1);
    // R3
    pair("R3", 1, 1, 1, 2, 3, 0,   1, 4, 1, 5, 0, 0, 0);
    pair("R3", 1, 1, 1, 2, 3, 0,   5, 0, 2, 1, 0, 0, 1);
    pair("R3", 1, 3, 2, 0, 0, 0,   4, 2, 0, 0, 0, 0, 0);
    // R4
    pair("R4", 1, 2, 1, 3, 0, 0,   1, 4, 1, 0, 1, 0, 1);
    pair("R4", 1, 2, 1, 3, 0, 0,   5, 0, 1, 0, 0, 0, 2);
    pair("R4", 1, 2, 1, 3, 0, 0,   5, 0, 1, 0, 0, 1, 1);
    pair("R4", 1, 2, 3, 4, 0, 0,   4, 3, 0, 0, 0, 0, 0);
    pair("R4", 1, 2, 1, 4, 0, 0,   4, 5, 1, 0, 0, 0, 1);
    // R5
    pair("R5", 1, 6, 5, 2, 3, 0,   5, 0, 5, 5, 0, 0, 0);
    pair("R5", 1, 6, 5, 2, 3, 0,   1, 6, 5, 5, 0, 0, 0);
    // R6
    pair("R6", 0, 1, 0, 2, 3, 0,   1, 4, 0, 0, 0, 0, 0);
    pair("R6", 0, 1, 4, 2, 3, 0,   1, 5, 0, 4, 1, 0, 0);
    pair("R6", 0, 2, 1, 2, 0, 0,   2, 3, 0, 1, 0, 0, 0);
    pair("R6", 0, 1, 4, 2, 3, 0,   4, 4, 0, 0, 0, 0, 3);
    pair("R6", 0, 1, 4, 2, 3, 0,   5, 4, 0, 4, 1, 0, 0);
    // R8
    pair("R8", 0, 4, 1, 2, 0, 0,   1, 3, 1, 1, 0, 0, 0);
    pair("R8", 0, 5, 1, 2, 3, 0,   1, 3, 1, 1, 0, 0, 0);
    // random streams, both modes; R9 bound on stall length
    for (int m = 0; m < 2; m++) begin
      fwd_en = m[0];
      idle(4);
      for (int i = 0; i < 2500; i++) begin
        if ($urandom_range(0, 7) == 0) begin
          idle(1);
        end else begin
          issue($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3) == 0, n);
          n_chk++;
          if (n > 3) begin
            n_fail++;
            $display("FAIL R9 stall run actual=%0d expected<=3", n);
          end
        end
      end
    end
    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule